// File: doc/BRIEF.md
# Strobe Watchdog with Undriven-Input Detection

This block watches a single strobe line for activity. Any transition on the strobe, rising or falling, restarts a timeout interval. If a whole interval passes with no transition, the active-low alarm output goes low and stays low until the strobe moves again or system reset is applied. Timing starts only once system reset is released, and a supply-low flag drives the alarm low at once, whatever the counter holds.

The block also lets a board leave the strobe open to turn the watchdog off. It drives a weak pull request that is low for the first seven eighths of each interval and high for the last eighth. If the strobe, after synchronisation, follows that request for one complete interval, the line is taken as undriven: the alarm is held inactive and transitions that only follow the pull are ignored. When the strobe takes a level opposite to the pull request, the line is taken as driven again and a new interval starts at once. The strobe passes through a two-flop synchroniser. A pulse that covers at least one full clock period is sampled and counts as two valid edges, so the clock must run fast enough for the shortest strobe pulse expected.

Everything is control-level. No port carries a data stream, so the block has no valid/ready handshake.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, `wdo_n` is high (unless `supply_low`), `pull_req` is low and `strobe_floating` is low. The interval count starts with the first clock edge after release.
- R2: If no valid strobe edge arrives in a full interval of `PERIOD_CYCLES` clocks and the strobe has not tracked the pull request, `wdo_n` goes low at the end of that interval.
- R3: A rising edge on a driven strobe restarts the interval. If the alarm is active, it clears within four clocks of the strobe changing.
- R4: A falling edge on a driven strobe restarts the interval and clears an active alarm in the same way as a rising edge.
- R5: Once low because of a timeout, `wdo_n` stays low for any number of intervals until a valid strobe edge arrives or `rst_n` is asserted.
- R6: While `supply_low` is 1, `wdo_n` is 0 in the same cycle, in reset and out of it.
- R7: `pull_req` is 0 for interval positions 0 to `PERIOD_CYCLES - PERIOD_CYCLES/8 - 1` and 1 for the final `PERIOD_CYCLES/8` positions. The pattern repeats every interval, counted from reset release or from the last restart.
- R8: A strobe that follows `pull_req` for a whole interval sets `strobe_floating` at the end of that interval and holds `wdo_n` high. Its pull-following transitions do not restart the interval.
- R9: While floating, a strobe level that opposes the pull request clears `strobe_floating` within four clocks and restarts the interval. Without further edges, a timeout follows one interval later.
- R10: A strobe pulse held for exactly one clock period is captured and acts as a valid edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| supply_low | input | 1 | Supply-low flag; forces the alarm active |
| strobe_in | input | 1 | Asynchronous watchdog strobe |
| pull_req | output | 1 | Weak pull direction request for the strobe pad (1 = pull high) |
| strobe_floating | output | 1 | 1 while the strobe is judged undriven |
| wdo_n | output | 1 | Watchdog alarm, active low |

## Verification
A fault in the interval counter shows at the ports first as a `pull_req` change one or more cycles off its expected position, long before the alarm timing drifts. The bench compares `pull_req` on every clock, so a counter fault is seen within one interval. A wrong tracking or floating state shows as `strobe_floating` or `wdo_n` differing from the model at the next interval boundary. A wrongly qualified edge shows as an alarm that clears or stays active against expectation within four clocks of the strobe change.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  // Current and previous synchronised level of one line.
  typedef struct packed {
    logic lvl;
    logic prev;
  } lvl_pair_t;

  // A transition that only reproduces the pull request, before and after,
  // says nothing about the strobe being driven.
  function automatic logic follows_pull(lvl_pair_t s, lvl_pair_t p);
    return (s.lvl == p.lvl) && (s.prev == p.prev);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync
  import wdog_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  output lvl_pair_t view
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign view = {chain_q[STAGES-1], prev_q};

endmodule

// File: rtl/pull_sequencer.sv
`timescale 1ns/1ps
module pull_sequencer
  import wdog_pkg::*;
#(
  parameter int PERIOD = 64,
  parameter int ALIGN  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  output logic      wrap,
  output logic      pull_req,
  output lvl_pair_t pull_view
);

  localparam int PH_W     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int HIGH_LEN = PERIOD / 8;
  localparam int LOW_LEN  = PERIOD - HIGH_LEN;
  localparam int LAST     = PERIOD - 1;

  logic [PH_W-1:0] phase_q;
  logic [ALIGN:0]  pd_q;

  assign wrap     = (phase_q == PH_W'(LAST));
  assign pull_req = (phase_q >= PH_W'(LOW_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n)                phase_q <= '0;
    else if (restart || wrap)  phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  // Delay the pull request by the synchroniser latency so it lines up
  // with what the strobe path shows.
  always_ff @(posedge clk) begin
    if (!rst_n) pd_q[0] <= 1'b0;
    else        pd_q[0] <= pull_req;
  end

  for (genvar i = 1; i <= ALIGN; i++) begin : g_pdly
    always_ff @(posedge clk) begin
      if (!rst_n) pd_q[i] <= 1'b0;
      else        pd_q[i] <= pd_q[i-1];
    end
  end

  assign pull_view = {pd_q[ALIGN-1], pd_q[ALIGN]};

  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_W'(LAST));
  // R7
  pull_rise_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_req) |-> (phase_q == PH_W'(LOW_LEN)));
  // R7
  pull_fall_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_req) |-> (phase_q == '0));

endmodule

// File: rtl/watchdog_core.sv
`timescale 1ns/1ps
module watchdog_core
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lvl_pair_t sv,
  input  lvl_pair_t pv,
  input  logic      wrap,
  output logic      restart,
  output logic      floating,
  output logic      timed_out
);

  logic track_q, floating_q, to_q;
  logic mism, vedge, float_break, end_ok;

  assign mism        = (sv.lvl != pv.lvl);
  assign vedge       = (sv.lvl != sv.prev) && !follows_pull(sv, pv);
  assign float_break = floating_q && mism && !vedge;
  assign end_ok      = track_q && !mism;
  assign restart     = vedge || float_break;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_q    <= 1'b1;
      floating_q <= 1'b0;
      to_q       <= 1'b0;
    end else if (vedge) begin
      track_q    <= !mism;
      floating_q <= 1'b0;
      to_q       <= 1'b0;
    end else if (float_break) begin
      track_q    <= 1'b0;
      floating_q <= 1'b0;
    end else if (wrap) begin
      track_q <= 1'b1;
      if (end_ok) begin
        floating_q <= 1'b1;
        to_q       <= 1'b0;
      end else begin
        to_q <= 1'b1;
      end
    end else if (mism) begin
      track_q <= 1'b0;
    end
  end

  assign floating  = floating_q;
  assign timed_out = to_q;

  // R2
  timeout_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(wrap));
  // R3
  edge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vedge |=> !to_q);
  // R5
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_q) |-> $past(vedge || (wrap && end_ok)));
  // R8
  float_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(floating_q) |-> $past(wrap));
  // R9
  float_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (floating_q && mism) |=> !floating_q);
  // R8
  float_no_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(floating_q && to_q));

endmodule

// File: rtl/strobe_watchdog.sv
`timescale 1ns/1ps
module strobe_watchdog
  import wdog_pkg::*;
#(
  parameter int PERIOD_CYCLES = 64,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic strobe_in,
  output logic pull_req,
  output logic strobe_floating,
  output logic wdo_n
);

  lvl_pair_t strobe_v, pull_v;
  logic      wrap, restart, timed_out;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (strobe_in),
    .view (strobe_v)
  );

  pull_sequencer #(.PERIOD(PERIOD_CYCLES), .ALIGN(SYNC_STAGES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .wrap     (wrap),
    .pull_req (pull_req),
    .pull_view(pull_v)
  );

  watchdog_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .sv       (strobe_v),
    .pv       (pull_v),
    .wrap     (wrap),
    .restart  (restart),
    .floating (strobe_floating),
    .timed_out(timed_out)
  );

  assign wdo_n = !(supply_low || timed_out);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |-> (!pull_req && !strobe_floating));

endmodule

// File: tb/strobe_watchdog_tb_top.sv
`timescale 1ns/1ps
module strobe_watchdog_tb_top;

  localparam int PER  = 64;
  localparam int LOWL = PER - PER / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_low = 1'b0;
  logic drv = 1'b0;
  logic float_mode = 1'b1;
  logic strobe_in;
  logic pull_req, strobe_floating, wdo_n;

  int n_chk = 0;
  int n_err = 0;
  bit started = 0;

  always #2 clk = ~clk;

  assign strobe_in = float_mode ? pull_req : drv;

  strobe_watchdog #(.PERIOD_CYCLES(PER), .SYNC_STAGES(2)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_low     (supply_low),
    .strobe_in      (strobe_in),
    .pull_req       (pull_req),
    .strobe_floating(strobe_floating),
    .wdo_n          (wdo_n)
  );

  // Behavioural reference: interval position, tracking verdict, flags,
  // and sample histories of strobe and pull kept in queues.
  int m_phase = 0;
  bit m_track = 1, m_float = 0, m_to = 0;
  bit sq[$] = '{0, 0, 0};
  bit pq[$] = '{0, 0, 0};
  bit pull_now, s_cur, s_old, p_cur, p_old, mis, ve, wr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_track = 1; m_float = 0; m_to = 0;
      sq = '{0, 0, 0}; pq = '{0, 0, 0};
    end else begin
      pull_now = (m_phase >= LOWL);
      s_cur = sq[1]; s_old = sq[2];
      p_cur = pq[1]; p_old = pq[2];
      mis = (s_cur != p_cur);
      ve  = (s_cur != s_old) && !((s_cur == p_cur) && (s_old == p_old));
      wr  = (m_phase == PER - 1);
      if (ve) begin
        m_phase = 0; m_track = !mis; m_to = 0; m_float = 0;
      end else if (m_float && mis) begin
        m_phase = 0; m_track = 0; m_float = 0;
      end else if (wr) begin
        m_phase = 0;
        if (m_track && !mis) begin m_float = 1; m_to = 0; end
        else m_to = 1;
        m_track = 1;
      end else begin
        m_phase = m_phase + 1;
        if (mis) m_track = 0;
      end
      sq.push_front(strobe_in); void'(sq.pop_back());
      pq.push_front(pull_now);  void'(pq.pop_back());
    end
    started = 1;
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  // Per-clock comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      chk("R6 wdo_n vs model", wdo_n, !(m_to || supply_low));
      chk("R7 pull_req vs model", pull_req, (m_phase >= LOWL));
      chk("R8 strobe_floating vs model", strobe_floating, m_float);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(5);
    #1;
    // R1 reset state
    chk("R1 wdo_n in reset", wdo_n, 1'b1);
    chk("R1 pull_req in reset", pull_req, 1'b0);
    chk("R1 floating in reset", strobe_floating, 1'b0);
    // R6 supply low during reset
    supply_low = 1'b1; #1;
    chk("R6 supply_low in reset", wdo_n, 1'b0);
    supply_low = 1'b0;
    cyc(1);
    rst_n = 1'b1;                     // j = 0
    // R7 pull pattern with a strobe following the pull
    cyc(LOWL - 1); #1;
    chk("R7 pull low at last low position", pull_req, 1'b0);
    cyc(1); #1;
    chk("R7 pull high at first high position", pull_req, 1'b1);
    cyc(PER - LOWL - 1); #1;
    chk("R7 pull high at last position", pull_req, 1'b1);
    cyc(1); #1;
    chk("R7 pull low after wrap", pull_req, 1'b0);
    // R8 floating declared at end of first full interval
    cyc(2); #1;
    chk("R8 floating declared", strobe_floating, 1'b1);
    chk("R8 alarm held inactive", wdo_n, 1'b1);
    cyc(2 * PER); #1;
    chk("R8 floating persists", strobe_floating, 1'b1);
    chk("R8 no timeout while floating", wdo_n, 1'b1);
    // R9 drive opposing level while pull is low
    cyc(8);
    drv = 1'b1; float_mode = 1'b0;
    cyc(4); #1;
    chk("R9 floating cleared", strobe_floating, 1'b0);
    cyc(PER - 3); #1;
    chk("R9 no alarm before interval ends", wdo_n, 1'b1);
    cyc(4); #1;
    chk("R2 alarm after idle interval", wdo_n, 1'b0);
    // R5 timeout holds over several intervals
    cyc(2 * PER); #1;
    chk("R5 alarm holds without edge", wdo_n, 1'b0);
    // R4 falling edge clears
    drv = 1'b0;
    cyc(4); #1;
    chk("R4 falling edge clears alarm", wdo_n, 1'b1);
    cyc(PER + 2); #1;
    chk("R2 second timeout", wdo_n, 1'b0);
    // R3 rising edge clears
    drv = 1'b1;
    cyc(4); #1;
    chk("R3 rising edge clears alarm", wdo_n, 1'b1);
    // R3 / R4 periodic strobe keeps alarm inactive
    for (int k = 0; k < 6; k++) begin
      cyc(PER / 2); #1;
      chk("R3 periodic strobe keeps alarm off", wdo_n, 1'b1);
      drv = ~drv;
    end
    drv = 1'b0;
    cyc(PER + 8); #1;
    chk("R2 idle low strobe times out", wdo_n, 1'b0);
    // R10 one-clock pulse
    drv = 1'b1;
    cyc(1);
    drv = 1'b0;
    cyc(4); #1;
    chk("R10 single-clock pulse clears alarm", wdo_n, 1'b1);
    // R6 supply low out of reset
    supply_low = 1'b1; #1;
    chk("R6 supply_low forces alarm", wdo_n, 1'b0);
    cyc(1);
    supply_low = 1'b0; #1;
    chk("R6 alarm released with supply", wdo_n, 1'b1);
    // R5 reset clears a timeout
    cyc(PER + 4); #1;
    chk("R5 timed out before reset", wdo_n, 1'b0);
    rst_n = 1'b0;
    cyc(2); #1;
    chk("R5 reset clears alarm", wdo_n, 1'b1);
    chk("R1 pull low in reset", pull_req, 1'b0);
    rst_n = 1'b1;
    // R8 floating detection after reset with an open strobe
    float_mode = 1'b1;
    cyc(PER + 3); #1;
    chk("R8 floating after reset", strobe_floating, 1'b1);
    cyc(4);
    finish_run();
  end

endmodule